// File: doc/BRIEF.md
# Fixed-Point Volume and Headroom Requantizer

This block multiplies a stream of 32-bit signed audio samples by a programmable linear volume gain. It then re-expresses the scaled sample in three fixed-point word formats. Each format has a different number of integer bits and therefore a different headroom above full scale. The formats are a wide volume format with 48 dB of headroom, a dynamics-stage format with 24 dB, and an output-stage format with no headroom at all.

Each conversion to a narrower format keeps the low-order bits and drops the top bits. A sample too large for a given format therefore wraps around instead of clipping to the rail. Every stage reports this with a sticky overflow flag. The block lets a designer see exactly which gain and level combinations distort a later stage.

Samples enter with a valid strobe. They leave two clock edges later, with the valid strobe carried alongside. The flags stay set until a clear input is asserted.

Top module: `headroom_chain`

## Requirements
- R1: The input sample is signed 1.31 and the gain is signed 9.23. `vol_sample` is the full product shifted right by 31 bits with floor rounding, keeping bits [62:31] of the 64-bit product as a signed 9.23 word.
- R2: `dyn_sample` is the 9.23 volume word reinterpreted as 5.27. It is the volume word shifted left by 4, with the top 4 bits discarded.
- R3: `dac_sample` is the volume word reinterpreted as 1.31. It is shifted left by 8 with the top 8 bits discarded, so an oversized value wraps and is never saturated.
- R4: An overflow is detected when the discarded upper bits of a conversion are not all equal to the sign bit of the kept word. The volume check covers product bits 63 and 62. The dynamics check covers volume bits [31:27]. The output check covers volume bits [31:23].
- R5: The flags `vol_ovf`, `dyn_ovf` and `dac_ovf` are sticky. `clr` clears them. An overflow that lands in the same cycle as `clr` still sets its flag.
- R6: A sample presented with `in_valid` appears on the outputs, with `out_valid` high, after two rising edges. Without `in_valid`, the sample outputs hold their values and `out_valid` is low.
- R7: A synchronous active-high `rst` zeroes every output and clears every flag.
- R8: Gains up to +48 dB (0x7FFFFFFF, just under 256.0) are accepted without volume-stage overflow for any input except -1.0 times -256.0.
- R9: At unity gain in the earlier stages, a full-scale input with more than +24 dB of gain overflows the dynamics format. A -9 dBFS input with +10 dB of gain overflows the output format. A -10 dBFS input with +10 dB of gain does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Clears the sticky overflow flags |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 32 | Signed 1.31 input sample |
| gain | input | 32 | Signed 9.23 linear volume gain |
| out_valid | output | 1 | Output sample strobe |
| vol_sample | output | 32 | Scaled sample, 9.23 |
| dyn_sample | output | 32 | Scaled sample, 5.27 |
| dac_sample | output | 32 | Scaled sample, 1.31 |
| vol_ovf | output | 1 | Sticky volume-stage overflow |
| dyn_ovf | output | 1 | Sticky dynamics-stage overflow |
| dac_ovf | output | 1 | Sticky output-stage overflow |

## Verification
The volume multiply is tried with several kinds of stimulus. Plain unity and power-of-two gains on positive and negative samples show that shifting and truncation are correct. Level pairs just above and just below each stage's limit separate a correct overflow boundary from an off-by-one in the discarded-bit range. A sample driven to exactly twice full scale in the output format tells wrapping apart from saturation. The two extreme products, -1 times -256 and -1 times just under +256, isolate the volume-stage check from the later ones, and a tiny negative sample exposes the rounding direction.

// File: rtl/headroom_chain.sv
module headroom_chain #(
  parameter int W       = 32,
  parameter int IN_INT  = 1,
  parameter int VOL_INT = 9,
  parameter int DYN_INT = 5,
  parameter int DAC_INT = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  input  logic [W-1:0] gain,
  output logic         out_valid,
  output logic [W-1:0] vol_sample,
  output logic [W-1:0] dyn_sample,
  output logic [W-1:0] dac_sample,
  output logic         vol_ovf,
  output logic         dyn_ovf,
  output logic         dac_ovf
);
  localparam int PSH    = W - IN_INT;
  localparam int DYN_SH = VOL_INT - DYN_INT;
  localparam int DAC_SH = VOL_INT - DAC_INT;

  logic signed [2*W-1:0] prod;
  logic [2*W-PSH-W:0]    p_top;
  logic                  p_bad;
  logic                  v1, vbad_q;
  logic [W-1:0]          vol_q;
  logic [DYN_SH:0]       d_top;
  logic [DAC_SH:0]       a_top;
  logic                  d_bad, a_bad;

  assign prod  = $signed(in_sample) * $signed(gain);
  assign p_top = prod[2*W-1:PSH+W-1];
  assign p_bad = !((&p_top) || !(|p_top));
  assign d_top = vol_q[W-1:W-1-DYN_SH];
  assign a_top = vol_q[W-1:W-1-DAC_SH];
  assign d_bad = !((&d_top) || !(|d_top));
  assign a_bad = !((&a_top) || !(|a_top));

  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      vol_q  <= '0;
      vbad_q <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        vol_q  <= prod[PSH+W-1:PSH];
        vbad_q <= p_bad;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      vol_sample <= '0;
      dyn_sample <= '0;
      dac_sample <= '0;
      vol_ovf    <= 1'b0;
      dyn_ovf    <= 1'b0;
      dac_ovf    <= 1'b0;
    end else begin
      out_valid <= v1;
      if (v1) begin
        vol_sample <= vol_q;
        dyn_sample <= {vol_q[W-1-DYN_SH:0], {DYN_SH{1'b0}}};
        dac_sample <= {vol_q[W-1-DAC_SH:0], {DAC_SH{1'b0}}};
      end
      vol_ovf <= (vol_ovf & ~clr) | (v1 & vbad_q);
      dyn_ovf <= (dyn_ovf & ~clr) | (v1 & d_bad);
      dac_ovf <= (dac_ovf & ~clr) | (v1 & a_bad);
    end
  end

  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> ($stable(vol_sample) && $stable(dac_sample) && !out_valid));
  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (dac_ovf && !clr) |=> dac_ovf);
  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !v1) |=> (!vol_ovf && !dyn_ovf && !dac_ovf));
  // R4
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dyn_ovf) |-> $past(v1));
  // R4
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (v1 && d_bad) |-> a_bad);
endmodule

// File: tb/sim_headroom_chain.sv
module sim_headroom_chain;
  logic        clk = 1'b0;
  logic        rst, clr, in_valid;
  logic [31:0] in_sample, gain;
  logic        out_valid, vol_ovf, dyn_ovf, dac_ovf;
  logic [31:0] vol_sample, dyn_sample, dac_sample;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  headroom_chain u0 (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
    .in_sample(in_sample), .gain(gain), .out_valid(out_valid),
    .vol_sample(vol_sample), .dyn_sample(dyn_sample), .dac_sample(dac_sample),
    .vol_ovf(vol_ovf), .dyn_ovf(dyn_ovf), .dac_ovf(dac_ovf)
  );

  localparam int N = 12;
  // in, gain, expected flags {vol,dyn,dac}
  localparam logic [31:0] VIN [N] = '{
    32'h40000000, 32'hE0000000, 32'h40000000, 32'd761900000,
    32'd679034330, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h80000000,
    32'h80000000, 32'h7FFFFFFF, 32'h00000100, 32'hFFFFFFFF};
  localparam logic [31:0] VG [N] = '{
    32'h00800000, 32'h01000000, 32'h02000000, 32'd26527294,
    32'd26527294, 32'd149170000, 32'd118490000, 32'h80000000,
    32'h7FFFFFFF, 32'h7FFFFFFF, 32'h00800000, 32'h00800000};
  localparam logic [2:0] VF [N] = '{
    3'b000, 3'b000, 3'b001, 3'b001, 3'b000, 3'b011,
    3'b001, 3'b111, 3'b011, 3'b011, 3'b000, 3'b000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic apply(input logic [31:0] s, input logic [31:0] g);
    @(negedge clk); in_valid = 1'b1; in_sample = s; gain = g;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  function automatic logic [31:0] ref_vol(input logic [31:0] s, input logic [31:0] g);
    longint p;
    p = longint'($signed(s)) * longint'($signed(g));
    p = p >>> 31;
    return p[31:0];
  endfunction

  initial begin
    logic [31:0] v;
    rst = 1'b1; clr = 1'b0; in_valid = 1'b0; in_sample = '0; gain = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 valid", {31'd0, out_valid}, 32'd0);
    chk("R7 vol", vol_sample, 32'd0);
    chk("R7 dac", dac_sample, 32'd0);
    chk("R7 flags", {29'd0, vol_ovf, dyn_ovf, dac_ovf}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      clear_flags();
      apply(VIN[i], VG[i]);
      v = ref_vol(VIN[i], VG[i]);
      chk($sformatf("R6 valid v%0d", i), {31'd0, out_valid}, 32'd1);
      chk($sformatf("R1 R8 vol v%0d", i), vol_sample, v);
      chk($sformatf("R2 dyn v%0d", i), dyn_sample, {v[27:0], 4'd0});
      chk($sformatf("R3 dac v%0d", i), dac_sample, {v[23:0], 8'd0});
      chk($sformatf("R4 R9 flags v%0d", i), {29'd0, vol_ovf, dyn_ovf, dac_ovf}, {29'd0, VF[i]});
    end

    // R3 wrap, not saturate: 2.0 in 1.31 becomes zero
    clear_flags();
    apply(32'h40000000, 32'h02000000);
    chk("R3 wrap", dac_sample, 32'h00000000);

    // R5 sticky across a clean sample
    apply(32'h40000000, 32'h00800000);
    chk("R5 sticky dac", {31'd0, dac_ovf}, 32'd1);
    chk("R5 clean data", dac_sample, 32'h40000000);
    clear_flags();
    chk("R5 clr", {29'd0, vol_ovf, dyn_ovf, dac_ovf}, 32'd0);

    // R5 overflow arriving together with clr
    @(negedge clk); in_valid = 1'b1; in_sample = 32'h40000000; gain = 32'h02000000;
    @(negedge clk); in_valid = 1'b0; clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R5 set beats clr", {31'd0, dac_ovf}, 32'd1);

    // R6 latency: not valid after one edge
    clear_flags();
    @(negedge clk); in_valid = 1'b1; in_sample = 32'h20000000; gain = 32'h00800000;
    @(negedge clk); in_valid = 1'b0;
    chk("R6 not yet", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R6 now", {31'd0, out_valid}, 32'd1);
    chk("R6 data", vol_sample, 32'h00200000);
    // R6 hold without valid
    in_sample = 32'h7FFFFFFF; gain = 32'h7FFFFFFF;
    repeat (3) @(negedge clk);
    chk("R6 hold vol", vol_sample, 32'h00200000);
    chk("R6 hold valid", {31'd0, out_valid}, 32'd0);
    chk("R6 hold flags", {29'd0, vol_ovf, dyn_ovf, dac_ovf}, 32'd0);

    // R7 mid-run reset
    apply(32'h40000000, 32'h02000000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R7 reset vol", vol_sample, 32'd0);
    chk("R7 reset dyn", dyn_sample, 32'd0);
    chk("R7 reset flags", {29'd0, vol_ovf, dyn_ovf, dac_ovf}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule